// File: doc/BRIEF.md
# USB Clock Source Divider

This block delivers the clock for a USB subsystem from one of two sources. When the dedicated USB PLL reports that it is connected, its clock is forwarded to the output unchanged. Otherwise the output is the main PLL clock divided down by an even ratio with a 50% duty cycle. Software sets the ratio through a one-byte configuration register. The ratio is the value of the register's low nibble plus one.

The divider runs in the main PLL clock domain. The connection flag is resynchronised into that domain by a short flop chain before it steers the output mux. Odd ratios cannot give a symmetric clock. For that reason an even nibble value is refused, and the divider holds whatever ratio it already had. A new ratio is taken up only on a rising edge of the divided output, so every high and low phase lasts a whole half-period of either the old or the new ratio.

Top module: `usbclk_src_div`

## Requirements
- R1: With `ded_connected` high, after the synchroniser stages (2 main clocks by default), `usb_clk` follows `clk_ded` edge for edge, whatever value is in the ratio field.
- R2: With `ded_connected` low and an odd field value N in force, `usb_clk` has a period of N+1 main clocks and stays high for (N+1)/2 of them (for example 5 gives 6, 7 gives 8, 9 gives 10).
- R3: The ratio field occupies bits 3:0 of the configuration byte. A write with `cfg_we` high stores bits 3:0, and `cfg_rdata[3:0]` returns the stored field.
- R4: An even field value, including 0, is unsupported. The divider keeps its previous ratio. If no odd value has ever been loaded since reset, `usb_clk` stays low.
- R5: An active-low asynchronous reset clears the field to 0, clears the divider and drives `usb_clk` low at once.
- R6: Bits 7:4 of a written byte are ignored, and `cfg_rdata[7:4]` always reads 0.
- R7: A ratio change takes effect at the next rising edge of the divided output. Each high or low phase lasts exactly the half-ratio of either the old or the new setting, and never a shorter runt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main PLL clock. It is the divider input and the register clock. |
| clk_ded | input | 1 | Dedicated USB PLL clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ded_connected | input | 1 | High when the dedicated PLL drives the USB clock |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write byte. The ratio field is in bits 3:0. |
| cfg_rdata | output | 8 | Configuration read byte. Bits 7:4 read as zero. |
| usb_clk | output | 1 | USB clock output |

## Verification
Two functions can fall on the same main clock edge: a register write that changes the ratio, and the divider's terminal count that flips the output. The bench provokes this by issuing the same 6-to-10 ratio change at every phase offset within one output period, so one of the writes lands on the edge that raises the output. Every high and low interval after the write is timed and must equal 3 or 5 main clocks. Once settled, the period must be 10.

// File: rtl/usbclk_pkg.sv
`timescale 1ns/1ps
package usbclk_pkg;
   // an odd field value selects an even division ratio
   function automatic bit field_is_odd(input int unsigned n);
      return (n % 2) == 1;
   endfunction

   // half of the division ratio (field + 1) / 2
   function automatic int unsigned half_ratio(input int unsigned n);
      return (n + 1) / 2;
   endfunction
endpackage

// File: rtl/usbclk_cfg_reg.sv
`timescale 1ns/1ps
module usbclk_cfg_reg #(
   parameter int REG_W   = 8,
   parameter int FIELD_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [REG_W-1:0]   wdata,
   output logic [FIELD_W-1:0] field,
   output logic [REG_W-1:0]   rdata
);
   localparam int PAD_W = REG_W - FIELD_W;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("usbclk_cfg_reg: REG_W must exceed FIELD_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  field <= '0;
      else if (we) field <= wdata[FIELD_W-1:0];
   end

   assign rdata = {{PAD_W{1'b0}}, field};

   // R3: the field changes only on a write
   p_field_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(field))
      else $error("field changed without a write");
endmodule

// File: rtl/usbclk_sync.sv
`timescale 1ns/1ps
module usbclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("usbclk_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0:0], d} ;
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/usbclk_even_div.sv
`timescale 1ns/1ps
module usbclk_even_div
   import usbclk_pkg::*;
#(
   parameter int FIELD_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] field,
   output logic               q
);
   localparam int HALF_W = FIELD_W;
   localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

   generate
      if (FIELD_W < 2 || FIELD_W > 16) begin : g_bad_field
         $error("usbclk_even_div: FIELD_W out of range");
      end
   endgenerate

   logic [HALF_W-1:0] half;
   logic [HALF_W-1:0] cnt;
   logic [HALF_W-1:0] new_half;
   logic              field_ok;
   logic              terminal;

   assign field_ok = field_is_odd(int'(field));
   assign new_half = HALF_W'(half_ratio(int'(field)));
   assign terminal = (cnt == half - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half <= '0;
         cnt  <= '0;
         q    <= 1'b0;
      end else if (half == '0) begin
         if (field_ok) begin
            half <= new_half;
            cnt  <= '0;
         end
      end else if (terminal) begin
         cnt <= '0;
         q   <= ~q;
         if (!q && field_ok) half <= new_half;
      end else begin
         cnt <= cnt + ONE;
      end
   end

   // R4: no ratio yet means the output rests low
   p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (half == '0) |-> !q)
      else $error("output high without a ratio");

   // R2: the counter stays inside the half-period
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (half != '0) |-> (cnt < half))
      else $error("counter past half-period");

   // R2: the output flips only after a full half-period count
   p_toggle_terminal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q != $past(q)) |-> ($past(cnt) == $past(half) - ONE))
      else $error("output flipped early");

   // R7: a running ratio is replaced only as the output rises
   p_change_at_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(half) != '0) && (half != $past(half))) |-> (q && !$past(q)))
      else $error("ratio swapped away from a rising edge");
endmodule

// File: rtl/usbclk_src_div.sv
`timescale 1ns/1ps
module usbclk_src_div #(
   parameter int REG_W       = 8,
   parameter int FIELD_W     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_main,
   input  logic             clk_ded,
   input  logic             rst_n,
   input  logic             ded_connected,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   output logic             usb_clk
);
   logic [FIELD_W-1:0] field;
   logic               sel_ded;
   logic               div_clk;

   usbclk_cfg_reg #(.REG_W(REG_W), .FIELD_W(FIELD_W)) u_cfg (
      .clk   (clk_main),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .field (field),
      .rdata (cfg_rdata)
   );

   usbclk_sync #(.STAGES(SYNC_STAGES)) u_sel_sync (
      .clk   (clk_main),
      .rst_n (rst_n),
      .d     (ded_connected),
      .q     (sel_ded)
   );

   usbclk_even_div #(.FIELD_W(FIELD_W)) u_div (
      .clk   (clk_main),
      .rst_n (rst_n),
      .field (field),
      .q     (div_clk)
   );

   assign usb_clk = sel_ded ? clk_ded : div_clk;
endmodule

// File: tb/usbclk_src_div_tb.sv
`timescale 1ns/1ps
module usbclk_src_div_tb;
   localparam real CLK_P = 4.0;
   localparam real DED_P = 20.0;
   localparam int  NV    = 8;
   // vector: {field, expected period, expected high time} in main clocks
   localparam int VEC [NV][3] = '{
      '{1, 2, 1}, '{3, 4, 2}, '{5, 6, 3}, '{7, 8, 4},
      '{9, 10, 5}, '{11, 12, 6}, '{13, 14, 7}, '{15, 16, 8}};

   logic       clk_main = 0;
   logic       clk_ded  = 0;
   logic       rst_n    = 0;
   logic       ded_connected = 0;
   logic       cfg_we   = 0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       usb_clk;

   int errors = 0;
   int checks = 0;

   always #(CLK_P/2) clk_main = ~clk_main;
   always #(DED_P/2) clk_ded  = ~clk_ded;

   usbclk_src_div u_dut (
      .clk_main      (clk_main),
      .clk_ded       (clk_ded),
      .rst_n         (rst_n),
      .ded_connected (ded_connected),
      .cfg_we        (cfg_we),
      .cfg_wdata     (cfg_wdata),
      .cfg_rdata     (cfg_rdata),
      .usb_clk       (usb_clk)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk_main);
      cfg_we = 1'b1;
      cfg_wdata = d;
      @(negedge clk_main);
      cfg_we = 1'b0;
   endtask

   task automatic measure(output int per, output int hi);
      realtime t0, t1, t2;
      @(posedge usb_clk); t0 = $realtime;
      @(negedge usb_clk); t1 = $realtime;
      @(posedge usb_clk); t2 = $realtime;
      per = int'((t2 - t0) / CLK_P);
      hi  = int'((t1 - t0) / CLK_P);
   endtask

   task automatic settle_measure(output int per, output int hi);
      int p0, h0;
      measure(p0, h0);
      measure(per, hi);
   endtask

   task automatic count_high(input int n, output int highs);
      highs = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk_main);
         if (usb_clk) highs++;
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int per, hi, highs;
      realtime e [5];

      // R5: reset state
      #10;
      check(usb_clk == 1'b0, "R5 reset output", int'(usb_clk), 0);
      check(cfg_rdata == 8'h00, "R5 reset field", int'(cfg_rdata), 0);
      @(negedge clk_main);
      rst_n = 1'b1;

      // R4: field 0 after reset keeps the output low
      count_high(40, highs);
      check(highs == 0, "R4 idle after reset", highs, 0);

      // R2, R3: every odd field value
      for (int v = 0; v < NV; v++) begin
         wr(8'(VEC[v][0]));
         check(cfg_rdata == 8'(VEC[v][0]), "R3 readback", int'(cfg_rdata), VEC[v][0]);
         settle_measure(per, hi);
         check(per == VEC[v][1], "R2 period", per, VEC[v][1]);
         check(hi == VEC[v][2], "R2 high time", hi, VEC[v][2]);
      end

      // R4: even values keep the ratio in force
      wr(8'h05);
      settle_measure(per, hi);
      wr(8'h04);
      check(cfg_rdata == 8'h04, "R4 even stored", int'(cfg_rdata), 4);
      settle_measure(per, hi);
      check(per == 6, "R4 even value ignored", per, 6);
      wr(8'h00);
      settle_measure(per, hi);
      check(per == 6 && hi == 3, "R4 zero ignored", per, 6);

      // R6: upper nibble ignored, reads zero
      wr(8'hF7);
      check(cfg_rdata == 8'h07, "R6 reserved bits read zero", int'(cfg_rdata), 7);
      settle_measure(per, hi);
      check(per == 8, "R6 reserved bits no effect", per, 8);

      // R7: ratio write at every phase of one output period
      for (int k = 0; k < 6; k++) begin
         wr(8'h05);
         settle_measure(per, hi);
         @(posedge usb_clk);
         repeat (k) @(posedge clk_main);
         wr(8'h09);
         for (int j = 0; j < 5; j++) begin
            @(usb_clk);
            e[j] = $realtime;
         end
         for (int j = 0; j < 4; j++) begin
            int d;
            d = int'((e[j+1] - e[j]) / CLK_P);
            check(d == 3 || d == 5, "R7 no runt phase", d, 5);
         end
         settle_measure(per, hi);
         check(per == 10, "R7 new ratio settled", per, 10);
      end

      // R1: bypass follows the dedicated clock, field ignored
      ded_connected = 1'b1;
      repeat (6) @(posedge clk_main);
      wr(8'h03);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk_ded); #1;
         check(usb_clk == 1'b1, "R1 bypass high", int'(usb_clk), 1);
         @(negedge clk_ded); #1;
         check(usb_clk == 1'b0, "R1 bypass low", int'(usb_clk), 0);
      end
      check(cfg_rdata == 8'h03, "R3 write during bypass", int'(cfg_rdata), 3);

      // R2: back on the divider with the stored field
      ded_connected = 1'b0;
      settle_measure(per, hi);
      check(per == 4 && hi == 2, "R2 after bypass", per, 4);

      // R5: asynchronous reset while the output is high
      wr(8'h09);
      settle_measure(per, hi);
      @(posedge usb_clk);
      #1 rst_n = 1'b0;
      #0.5;
      check(usb_clk == 1'b0, "R5 async reset output", int'(usb_clk), 0);
      check(cfg_rdata == 8'h00, "R5 async reset field", int'(cfg_rdata), 0);
      repeat (3) @(negedge clk_main);
      rst_n = 1'b1;
      count_high(30, highs);
      check(highs == 0, "R4 idle after mid-run reset", highs, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule